// File: doc/BRIEF.md
# Configuration Readback Signature Checker

This block scrubs the configuration memory of a programmable device without outside help. It walks a short list of frame addresses held in a small on-chip table. For each frame it sends a fixed readback command sequence to the internal configuration port, then takes that frame's data words back. Every returned word is folded into a running CRC-32. When the list runs out, one pass is complete and the pass signature is presented.

The first complete pass after reset becomes the reference signature. Each later pass is compared with that reference. A mismatch sets a sticky failure flag, which system mitigation logic can act on, for example by starting a device reconfiguration.

The address table is written through a simple write port while the checker is idle. The configuration port is modelled as two 32-bit valid/ready channels: a command channel out of the block and a readback data channel into it. The `run` input lets passes repeat back to back. When `run` is low, the block stops between passes.

Top module: `cfg_scrub_checker`

## Requirements
- R1: While reset is active and just after it, `cmd_valid`, `rd_ready`, `pass_done`, `golden_valid` and `cfg_fail` are all 0.
- R2: Table entries written through `lst_we`/`lst_widx`/`lst_wdata` are visited in ascending index order, starting from index 0 on every pass.
- R3: Each frame is preceded by exactly 11 command words (44 bytes). Word k, for k = 0..10, is 32'hA5C3_0000 + k, except word 6, which carries the 32-bit frame address taken from the table.
- R4: After the last command word of a frame is accepted, exactly FRAME_WORDS readback words are accepted for that frame. `rd_ready` is high only in this phase and is never high together with `cmd_valid`.
- R5: A stall on either channel pauses the sequence without loss. `cmd_data` holds steady while `cmd_valid` is high and `cmd_ready` is low, and a readback word counts only on a cycle where both `rd_valid` and `rd_ready` are high.
- R6: A pass ends at the first entry equal to 32'hFFFF_FFFF, or after LIST_DEPTH entries if no such entry exists. `pass_done` is then high for exactly one cycle, and in that cycle `pass_sig` holds the pass signature.
- R7: The signature is the reflected CRC-32: polynomial 0xEDB88320, start value all ones, final inversion. Each 32-bit word is fed least-significant bit first, which is the same as its four bytes in little-endian order. The CRC restarts at every pass.
- R8: On the first pass after reset, the signature is stored as the reference. `golden_valid` rises in the cycle after `pass_done` and then stays high with the reference unchanged.
- R9: On a later pass whose signature differs from the reference, `cfg_fail` rises in the cycle after `pass_done` and stays high until reset. A matching pass leaves `cfg_fail` unchanged.
- R10: While `run` is low after a pass, no new pass starts: `cmd_valid`, `rd_ready` and `pass_done` stay 0.
- R11: A table whose entry 0 is the end marker gives a pass with no commands at all and a signature of 32'h0000_0000.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start (or keep repeating) passes while high |
| lst_we | input | 1 | Address table write enable |
| lst_widx | input | $clog2(LIST_DEPTH) | Address table write index |
| lst_wdata | input | 32 | Address table write data (frame address or end marker) |
| cmd_valid | output | 1 | Command word valid toward configuration port |
| cmd_ready | input | 1 | Configuration port accepts command word |
| cmd_data | output | 32 | Command word |
| rd_valid | input | 1 | Readback word valid from configuration port |
| rd_ready | output | 1 | Checker accepts readback word |
| rd_data | input | 32 | Readback word |
| pass_done | output | 1 | One-cycle pulse at the end of a pass |
| pass_sig | output | 32 | Signature of the pass, valid with pass_done |
| golden_valid | output | 1 | Reference signature has been learned |
| cfg_fail | output | 1 | Sticky mismatch flag |

## Verification
The embedded properties assume the configuration port keeps to the valid/ready rules and that the address table is written only while `run` is low and the block is idle. The bench's port model follows these rules. It raises `cmd_ready` and `rd_valid` at random, never drops a readback word it has offered, and sends readback data only after a frame's full command sequence. It writes the table only between passes, with `run` held low. Fault injection changes the readback data of one frame on one pass. This keeps every handshake legal while the signature changes.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;
  localparam int          CMD_WORDS     = 11;
  localparam int          CMD_ADDR_SLOT = 6;
  localparam logic [31:0] CMD_BASE      = 32'hA5C3_0000;
  localparam logic [31:0] LIST_END      = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R    = 32'hEDB8_8320;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CMD, ST_DATA, ST_FIN
  } seq_state_t;

  // fold one word into a reflected CRC-32, bit 0 first
  function automatic logic [31:0] crc32_word(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 32; i++) begin
      if ((r[0] ^ d[i]) == 1'b1) r = (r >> 1) ^ CRC_POLY_R;
      else                       r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] cmd_word(input int unsigned k, input logic [31:0] addr);
    if (k == CMD_ADDR_SLOT) return addr;
    return CMD_BASE + k;
  endfunction
endpackage

// File: rtl/cfgchk_addr_mem.sv
module cfgchk_addr_mem #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [31:0]   rd_data
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/cfgchk_crc_acc.sv
module cfgchk_crc_acc
  import cfgchk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        upd,
  input  logic [31:0] din,
  input  logic        fin,
  output logic [31:0] sig,
  output logic        golden_valid,
  output logic        cfg_fail
);
  logic [31:0] crc;
  logic [31:0] golden;

  assign sig = ~crc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc          <= '1;
      golden       <= '0;
      golden_valid <= 1'b0;
      cfg_fail     <= 1'b0;
    end else begin
      if (clear)    crc <= '1;
      else if (upd) crc <= crc32_word(crc, din);
      if (fin) begin
        if (!golden_valid) begin
          golden       <= sig;
          golden_valid <= 1'b1;
        end else if (sig != golden) begin
          cfg_fail <= 1'b1;
        end
      end
    end
  end

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fail |=> cfg_fail);
  // R9
  fail_after_golden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_fail) |-> $past(golden_valid) && $past(fin));
  // R8
  golden_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    golden_valid |=> golden_valid && $stable(golden));
  // R8
  golden_learn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(golden_valid) |-> $past(fin));
endmodule

// File: rtl/cfgchk_seq.sv
module cfgchk_seq
  import cfgchk_pkg::*;
#(
  parameter int FRAME_WORDS = 4,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IW = AW + 1,
  localparam int CW = $clog2(CMD_WORDS),
  localparam int WW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [AW-1:0] list_idx,
  input  logic [31:0]   list_entry,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [31:0]   cmd_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  output logic          crc_clear,
  output logic          crc_upd,
  output logic          pass_fin
);
  seq_state_t    st;
  logic [IW-1:0] idx;
  logic [CW-1:0] ccnt;
  logic [WW-1:0] wcnt;
  logic [31:0]   far;
  logic          list_end;
  logic          cmd_last;
  logic          word_last;

  assign list_idx  = idx[AW-1:0];
  assign list_end  = (idx == IW'(DEPTH)) || (list_entry == LIST_END);
  assign cmd_last  = (ccnt == CW'(CMD_WORDS - 1));
  assign word_last = (wcnt == WW'(FRAME_WORDS - 1));
  assign cmd_valid = (st == ST_CMD);
  assign cmd_data  = cmd_word(int'(ccnt), far);
  assign rd_ready  = (st == ST_DATA);
  assign crc_clear = (st == ST_IDLE) && run;
  assign crc_upd   = rd_valid && rd_ready;
  assign pass_fin  = (st == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      idx  <= '0;
      ccnt <= '0;
      wcnt <= '0;
      far  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (run) begin
          idx <= '0;
          st  <= ST_FETCH;
        end
        ST_FETCH: if (list_end) st <= ST_FIN;
        else begin
          far  <= list_entry;
          ccnt <= '0;
          st   <= ST_CMD;
        end
        ST_CMD: if (cmd_ready) begin
          if (cmd_last) begin
            wcnt <= '0;
            st   <= ST_DATA;
          end else ccnt <= ccnt + 1'b1;
        end
        ST_DATA: if (rd_valid) begin
          if (word_last) begin
            idx <= idx + 1'b1;
            st  <= ST_FETCH;
          end else wcnt <= wcnt + 1'b1;
        end
        ST_FIN: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));
  // R4
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rd_ready));
  // R4
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_upd && word_last |=> !rd_ready && !cmd_valid);
  // R6
  pass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_fin |=> !pass_fin);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) && !run |=> !cmd_valid && !rd_ready && !pass_fin);
endmodule

// File: rtl/cfg_scrub_checker.sv
module cfg_scrub_checker
  import cfgchk_pkg::*;
#(
  parameter int FRAME_WORDS = 4,
  parameter int LIST_DEPTH  = 8,
  localparam int AW = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          lst_we,
  input  logic [AW-1:0] lst_widx,
  input  logic [31:0]   lst_wdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [31:0]   cmd_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [31:0]   rd_data,
  output logic          pass_done,
  output logic [31:0]   pass_sig,
  output logic          golden_valid,
  output logic          cfg_fail
);
  logic [AW-1:0] list_idx;
  logic [31:0]   list_entry;
  logic          crc_clear;
  logic          crc_upd;

  cfgchk_addr_mem #(.DEPTH(LIST_DEPTH)) u_list (
    .clk(clk), .wr_en(lst_we), .wr_idx(lst_widx), .wr_data(lst_wdata),
    .rd_idx(list_idx), .rd_data(list_entry)
  );

  cfgchk_seq #(.FRAME_WORDS(FRAME_WORDS), .DEPTH(LIST_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run),
    .list_idx(list_idx), .list_entry(list_entry),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .crc_clear(crc_clear), .crc_upd(crc_upd), .pass_fin(pass_done)
  );

  cfgchk_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crc_clear), .upd(crc_upd), .din(rd_data),
    .fin(pass_done), .sig(pass_sig), .golden_valid(golden_valid), .cfg_fail(cfg_fail)
  );
endmodule

// File: tb/cfg_scrub_checker_tb.sv
module cfg_scrub_checker_tb;
  localparam int FW = 4;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic lst_we = 1'b0;
  logic [2:0] lst_widx = '0;
  logic [31:0] lst_wdata = '0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [31:0] cmd_data;
  logic rd_valid = 1'b0, rd_ready;
  logic [31:0] rd_data = '0;
  logic pass_done, golden_valid, cfg_fail;
  logic [31:0] pass_sig;

  always #2.5 clk = ~clk;

  cfg_scrub_checker #(.FRAME_WORDS(FW), .LIST_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .lst_we(lst_we), .lst_widx(lst_widx),
    .lst_wdata(lst_wdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .pass_done(pass_done), .pass_sig(pass_sig), .golden_valid(golden_valid),
    .cfg_fail(cfg_fail)
  );

  int n_chk = 0, n_fail = 0, cmd_seen = 0, pass_seen = 0;
  logic [31:0] exp_cmd[$];
  logic [31:0] exp_sig[$];
  logic [31:0] cur_list[DEPTH];
  int cur_len = 0;
  logic inj_on = 1'b0;
  logic [31:0] inj_addr = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // frame content model and fault injection on word 1 of one frame
  function automatic logic [31:0] frame_word(input logic [31:0] a, input int k);
    logic [31:0] w;
    w = a * 32'h0100_0193 + k * 32'h0001_0001;
    if (inj_on && a == inj_addr && k == 1) w = w ^ 32'h0000_0100;
    return w;
  endfunction

  // byte-wise reflected CRC-32, little-endian bytes (R7)
  function automatic logic [31:0] crc_bytes(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 4; b++) begin
      r = r ^ {24'h0, w[8*b +: 8]};
      for (int j = 0; j < 8; j++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  // driver side of scoreboard: expected command words and signature for a pass
  task automatic queue_pass();
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int f = 0; f < cur_len; f++) begin
      for (int k = 0; k < 11; k++)
        exp_cmd.push_back(k == 6 ? cur_list[f] : 32'hA5C3_0000 + k);
      for (int k = 0; k < FW; k++) c = crc_bytes(c, frame_word(cur_list[f], k));
    end
    exp_sig.push_back(~c);
  endtask

  task automatic load_list(input int n, input bit sentinel);
    for (int i = 0; i < DEPTH; i++) begin
      if (i < n || (sentinel && i == n)) begin
        @(negedge clk);
        lst_we = 1'b1; lst_widx = 3'(i);
        lst_wdata = (i < n) ? cur_list[i] : 32'hFFFF_FFFF;
      end
    end
    @(negedge clk); lst_we = 1'b0;
    cur_len = n;
  endtask

  task automatic do_pass();
    queue_pass();
    @(negedge clk); run = 1'b1;
    @(negedge clk);
    while (!pass_done) @(negedge clk);
    run = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; run = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // configuration port model (responder + command monitor)
  int resp_n = 0, resp_left = 0, resp_k = 0;
  logic [31:0] resp_addr = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_ready = 1'b0; rd_valid = 1'b0;
      resp_n = 0; resp_left = 0; resp_k = 0;
    end else begin
      logic r, v;
      logic [31:0] e;
      r = ($urandom_range(0, 3) != 0);
      cmd_ready = r;
      if (cmd_valid && r) begin
        cmd_seen++;
        if (exp_cmd.size() == 0) chk(1'b0, "R3 unexpected command", cmd_data, 32'h0);
        else begin
          e = exp_cmd.pop_front();
          chk(cmd_data == e, "R3/R2 command word", cmd_data, e);
        end
        if (resp_n == 6) resp_addr = cmd_data;
        resp_n++;
        if (resp_n == 11) begin resp_n = 0; resp_left = FW; resp_k = 0; end
      end
      if (resp_left > 0) begin
        v = ($urandom_range(0, 2) != 0);
        rd_valid = v;
        rd_data = frame_word(resp_addr, resp_k);
        if (v && rd_ready) begin resp_k++; resp_left--; end
      end else rd_valid = 1'b0;
    end
  end

  // signature monitor
  always @(negedge clk) begin
    if (rst_n && pass_done) begin
      pass_seen++;
      if (exp_sig.size() == 0) chk(1'b0, "R6 unexpected pass_done", pass_sig, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_sig.pop_front();
        chk(pass_sig == e, "R7/R5 pass signature", pass_sig, e);
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      report();
    end
  end

  initial begin
    int c0, p0, busy;
    cur_list[0] = 32'h0001_2000; cur_list[1] = 32'h0003_4400;
    cur_list[2] = 32'h0ABC_0100; cur_list[3] = 32'h0042_0000;
    cur_list[4] = 32'h0050_0A00; cur_list[5] = 32'h0066_0010;
    cur_list[6] = 32'h0077_7700; cur_list[7] = 32'h0080_0001;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!cmd_valid && !rd_ready, "R1 channels idle in reset", {cmd_valid, rd_ready}, 0);
    chk(!pass_done && !golden_valid && !cfg_fail, "R1 flags clear in reset",
        {pass_done, golden_valid, cfg_fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid && !golden_valid && !cfg_fail, "R1 flags after reset",
        {cmd_valid, golden_valid, cfg_fail}, 0);

    load_list(3, 1'b1);
    do_pass();  // R8 first pass learns reference
    chk(!golden_valid, "R8 golden not yet valid at pass_done", golden_valid, 0);
    @(negedge clk);
    chk(golden_valid, "R8 golden valid after first pass", golden_valid, 1);
    chk(!cfg_fail, "R8 no fail on first pass", cfg_fail, 0);

    do_pass();  // matching pass
    @(negedge clk);
    chk(!cfg_fail, "R9 matching pass leaves fail low", cfg_fail, 0);

    inj_on = 1'b1; inj_addr = 32'h0003_4400;
    do_pass();  // corrupted pass
    chk(!cfg_fail, "R9 fail not before the cycle after pass_done", cfg_fail, 0);
    @(negedge clk);
    chk(cfg_fail, "R9 fail on mismatch", cfg_fail, 1);
    inj_on = 1'b0;

    do_pass();  // clean again: sticky
    @(negedge clk);
    chk(cfg_fail, "R9 fail is sticky", cfg_fail, 1);

    // R10 run low: nothing happens
    c0 = cmd_seen; p0 = pass_seen; busy = 0;
    repeat (30) begin @(negedge clk); if (cmd_valid || rd_ready || pass_done) busy++; end
    chk(busy == 0 && cmd_seen == c0 && pass_seen == p0, "R10 quiet while run low", busy, 0);

    // R6 list with no end marker stops after LIST_DEPTH entries; R8 fresh golden
    do_reset();
    chk(!golden_valid && !cfg_fail, "R1 flags cleared by reset", {golden_valid, cfg_fail}, 0);
    load_list(DEPTH, 1'b0);
    c0 = cmd_seen;
    do_pass();
    @(negedge clk);
    chk(cmd_seen - c0 == DEPTH * 11, "R6 full-depth pass command count", cmd_seen - c0, DEPTH * 11);
    chk(golden_valid && !cfg_fail, "R8 golden learned after reset", {golden_valid, cfg_fail}, 2);

    // R11 empty list
    do_reset();
    load_list(0, 1'b1);
    c0 = cmd_seen;
    do_pass();
    chk(pass_sig == 32'h0, "R11 empty list signature", pass_sig, 32'h0);
    @(negedge clk);
    chk(cmd_seen == c0, "R11 no commands on empty list", cmd_seen - c0, 0);
    chk(exp_cmd.size() == 0 && exp_sig.size() == 0, "R4 scoreboard drained",
        exp_cmd.size() + exp_sig.size(), 0);
    repeat (5) @(negedge clk);
    done = 1;
    report();
  end
endmodule